// File: doc/BRIEF.md
# Ternary Raster Operation Datapath

This block is the combining stage of a 2D drawing engine. Each word it receives holds four 8-bit pixels of pattern, source and destination data. For every bit, an 8-bit operation code chooses one of the 256 Boolean functions of those three operands. The source can instead arrive as monochrome bits, one per pixel, which the block turns into colour by choosing a foreground or a background value. Pattern and source transparency do not change the result data. They clear per-pixel byte enables, so the memory write that follows leaves those pixels untouched.

Words enter on a valid/ready stream and leave on a second valid/ready stream, with a byte-enable vector beside each result. The block has two register stages. The operation code, the colours and the mode enables are taken with each word when the input handshake completes. Software may therefore change them between words without draining the pipeline.

Top module: `rop3_blend`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: For each bit b, `outData[b]` equals `ropCode[{P,S,D}]`. P is the pattern bit, S is the effective source bit and D is the destination bit, with P as the most significant index bit. Code F0h copies the pattern, CCh copies the source and AAh copies the destination.
- R3: With `expandEn` = 1, `srcWord[i]` selects the source for pixel i, which is bits 8i+7..8i. A 1 selects `fgColor` and a 0 selects `bgColor`. Bits 31..4 of `srcWord` are ignored.
- R4: With `expandEn` = 0, `srcWord` is used unchanged as the source operand.
- R5: With `patTransEn` = 1, `outByteEn[i]` is 0 for every pixel whose `patMask[i]` is 0. The data is still computed.
- R6: With `srcTransEn` = 1 and `expandEn` = 1, `outByteEn[i]` is 0 for every pixel whose `srcWord[i]` is 0. With `expandEn` = 0, source transparency has no effect.
- R7: With both transparency enables at 0, `outByteEn` is all ones.
- R8: If the input handshake completes at clock edge k into an empty pipeline with `outReady` high, the word is presented with `outValid` = 1 after edge k+1, and not before.
- R9: While `outValid` = 1 and `outReady` = 0, `outValid`, `outData` and `outByteEn` hold. Words leave in the order they were accepted, with none lost and none repeated.
- R10: `inReady` is 0 exactly when both stages are occupied and `outReady` is 0.
- R11: The configuration inputs are sampled with each word at acceptance, so consecutive words may use different configurations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is present |
| inReady | output | 1 | Block can accept a word |
| patWord | input | 32 | Pattern operand, four pixels |
| patMask | input | 4 | Monochrome pattern bit per pixel, used for transparency |
| srcWord | input | 32 | Source operand, or monochrome bits in 3..0 when expanding |
| dstWord | input | 32 | Destination operand |
| ropCode | input | 8 | Ternary raster operation code |
| fgColor | input | 8 | Colour chosen by a 1 source bit |
| bgColor | input | 8 | Colour chosen by a 0 source bit |
| expandEn | input | 1 | Monochrome-to-colour source expansion |
| patTransEn | input | 1 | Pattern transparency enable |
| srcTransEn | input | 1 | Source transparency enable |
| outValid | output | 1 | Result word is present |
| outReady | input | 1 | Consumer accepts the result |
| outData | output | 32 | Result word |
| outByteEn | output | 4 | Write enable per pixel byte |

## Verification
The hardest state to reach is a full stall. In that state both stages hold words and the consumer refuses, so `inReady` must fall while a third word is waiting. A directed sequence holds `outReady` low and keeps `inValid` high across three edges. It then checks that the front word holds still and that the drain returns both stored words in order. The vector table is streamed under an irregular `outReady` pattern, with the configuration changing on every word. This exercises stalls that land between words carrying different operation codes and modes.

// File: rtl/rop3_pkg.sv
package rop3_pkg;

  typedef struct packed {
    logic loadFront;  // stage 1 captures the incoming word
    logic loadBack;   // stage 2 captures stage 1
  } pipeStrobe_t;

endpackage

// File: rtl/rop3_ctrl.sv
module rop3_ctrl
  import rop3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output pipeStrobe_t strobe
);

  logic frontFull;
  logic backFull;

  always_comb begin
    strobe.loadBack  = frontFull && (!backFull || outReady);
    inReady          = !frontFull || strobe.loadBack;
    strobe.loadFront = inValid && inReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontFull <= 1'b0;
      backFull  <= 1'b0;
    end else begin
      if (strobe.loadFront)     frontFull <= 1'b1;
      else if (strobe.loadBack) frontFull <= 1'b0;
      if (strobe.loadBack)      backFull  <= 1'b1;
      else if (outReady)        backFull  <= 1'b0;
    end
  end

  assign outValid = backFull;

endmodule

// File: rtl/rop3_dpath.sv
module rop3_dpath
  import rop3_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int PIX_N = 4,
  localparam int DATA_W = PIX_W * PIX_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeStrobe_t       strobe,
  input  logic [DATA_W-1:0] patWord,
  input  logic [PIX_N-1:0]  patMask,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [7:0]        ropCode,
  input  logic [PIX_W-1:0]  fgColor,
  input  logic [PIX_W-1:0]  bgColor,
  input  logic              expandEn,
  input  logic              patTransEn,
  input  logic              srcTransEn,
  output logic [DATA_W-1:0] outData,
  output logic [PIX_N-1:0]  outByteEn
);

  logic [DATA_W-1:0] srcEff;
  logic [PIX_N-1:0]  enNext;

  // Source expansion and per-pixel enables
  for (genvar px = 0; px < PIX_N; px++) begin : gPix
    logic monoBit;
    assign monoBit = srcWord[px];
    assign srcEff[px*PIX_W +: PIX_W] =
      expandEn ? (monoBit ? fgColor : bgColor) : srcWord[px*PIX_W +: PIX_W];
    assign enNext[px] = !(patTransEn && !patMask[px]) &&
                        !(srcTransEn && expandEn && !monoBit);
  end

  // Stage 1: operands, effective source, enables and code travel together
  logic [DATA_W-1:0] frontPat;
  logic [DATA_W-1:0] frontSrc;
  logic [DATA_W-1:0] frontDst;
  logic [7:0]        frontRop;
  logic [PIX_N-1:0]  frontEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontPat <= '0;
      frontSrc <= '0;
      frontDst <= '0;
      frontRop <= '0;
      frontEn  <= '0;
    end else if (strobe.loadFront) begin
      frontPat <= patWord;
      frontSrc <= srcEff;
      frontDst <= dstWord;
      frontRop <= ropCode;
      frontEn  <= enNext;
    end
  end

  // Bitwise ternary function: the code is a truth table indexed by {P,S,D}
  logic [DATA_W-1:0] ropResult;
  for (genvar b = 0; b < DATA_W; b++) begin : gBit
    logic [2:0] sel;
    assign sel          = {frontPat[b], frontSrc[b], frontDst[b]};
    assign ropResult[b] = frontRop[sel];
  end

  // Stage 2: result register feeding the output stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outByteEn <= '0;
    end else if (strobe.loadBack) begin
      outData   <= ropResult;
      outByteEn <= frontEn;
    end
  end

endmodule

// File: rtl/rop3_blend.sv
module rop3_blend
  import rop3_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int PIX_N = 4,
  localparam int DATA_W = PIX_W * PIX_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] patWord,
  input  logic [PIX_N-1:0]  patMask,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [7:0]        ropCode,
  input  logic [PIX_W-1:0]  fgColor,
  input  logic [PIX_W-1:0]  bgColor,
  input  logic              expandEn,
  input  logic              patTransEn,
  input  logic              srcTransEn,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [PIX_N-1:0]  outByteEn
);

  pipeStrobe_t strobe;

  rop3_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  rop3_dpath #(.PIX_W(PIX_W), .PIX_N(PIX_N)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .patWord    (patWord),
    .patMask    (patMask),
    .srcWord    (srcWord),
    .dstWord    (dstWord),
    .ropCode    (ropCode),
    .fgColor    (fgColor),
    .bgColor    (bgColor),
    .expandEn   (expandEn),
    .patTransEn (patTransEn),
    .srcTransEn (srcTransEn),
    .outData    (outData),
    .outByteEn  (outByteEn)
  );

endmodule

// File: rtl/rop3_blend_chk.sv
module rop3_blend_chk #(
  parameter int DATA_W = 32,
  parameter int PIX_N  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [PIX_N-1:0]  outByteEn
);

  // R1: the pipeline comes out of reset empty and open
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady));

  // R9: a refused word stays presented
  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R9: a refused word does not change
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outByteEn)));

  // R10: input closes only under a stalled full output
  assert_ready_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (outValid && !outReady));

endmodule

bind rop3_blend rop3_blend_chk #(.DATA_W(DATA_W), .PIX_N(PIX_N)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .outByteEn (outByteEn)
);

// File: tb/sim_rop3_blend.sv
module sim_rop3_blend;

  localparam int NV = 12;

  typedef struct packed {
    logic [7:0]  rop;
    logic [7:0]  fg;
    logic [7:0]  bg;
    logic        exp;
    logic        pTr;
    logic        sTr;
    logic [3:0]  pMask;
    logic [31:0] pat;
    logic [31:0] src;
    logic [31:0] dst;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'hF0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F},
    '{8'hCC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F},
    '{8'hAA, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F},
    '{8'h66, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'hFFFF0000, 32'hA5A5A5A5, 32'h3C3C3C3C},
    '{8'h96, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'hFF00FF00, 32'hA5A5A5A5, 32'h3C3C3C3C},
    '{8'hCC, 8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, 4'hF, 32'h00000000, 32'h00000005, 32'h77777777},
    '{8'hCC, 8'h81, 8'h18, 1'b1, 1'b0, 1'b1, 4'hF, 32'h00000000, 32'hFFFFFFF6, 32'h00000000},
    '{8'hF0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 4'h9, 32'hDEADBEEF, 32'h00000000, 32'h11111111},
    '{8'hB8, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b1, 4'hC, 32'hC3C3C3C3, 32'h0000000A, 32'h55AA55AA},
    '{8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 4'hF, 32'h00000000, 32'h00000000, 32'h00000000},
    '{8'hC0, 8'h6E, 8'h91, 1'b1, 1'b0, 1'b0, 4'hF, 32'hF0F0FF00, 32'h00000003, 32'h12121212}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] patWord = '0;
  logic [3:0]  patMask = '0;
  logic [31:0] srcWord = '0;
  logic [31:0] dstWord = '0;
  logic [7:0]  ropCode = '0;
  logic [7:0]  fgColor = '0;
  logic [7:0]  bgColor = '0;
  logic        expandEn = 1'b0;
  logic        patTransEn = 1'b0;
  logic        srcTransEn = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic [3:0]  outByteEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rop3_blend u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .patWord(patWord), .patMask(patMask), .srcWord(srcWord), .dstWord(dstWord),
    .ropCode(ropCode), .fgColor(fgColor), .bgColor(bgColor),
    .expandEn(expandEn), .patTransEn(patTransEn), .srcTransEn(srcTransEn),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outByteEn(outByteEn)
  );

  function automatic logic [31:0] expData(vec_t v);
    logic [31:0] s;
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      s[i*8 +: 8] = v.exp ? (v.src[i] ? v.fg : v.bg) : v.src[i*8 +: 8];
    for (int b = 0; b < 32; b++)
      r[b] = v.rop[{v.pat[b], s[b], v.dst[b]}];
    return r;
  endfunction

  function automatic logic [3:0] expBe(vec_t v);
    logic [3:0] e;
    for (int i = 0; i < 4; i++)
      e[i] = !(v.pTr && !v.pMask[i]) && !(v.sTr && v.exp && !v.src[i]);
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ropCode = v.rop; fgColor = v.fg; bgColor = v.bg;
    expandEn = v.exp; patTransEn = v.pTr; srcTransEn = v.sTr;
    patMask = v.pMask; patWord = v.pat; srcWord = v.src; dstWord = v.dst;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int inIdx;
    int outIdx;
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!outValid, "R1 outValid after reset", {31'd0, outValid}, 32'd0);
    chk(inReady, "R1 inReady after reset", {31'd0, inReady}, 32'd1);

    // Table streamed with an irregular consumer
    inIdx = 0; outIdx = 0; cyc = 0;
    while (outIdx < NV && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      outReady = !((cyc % 5) == 2 || (cyc % 3) == 0);
      inValid = (inIdx < NV);
      if (inIdx < NV) drive(VECS[inIdx]);
      #1;
      if (outValid && outReady) begin
        chk(outData == expData(VECS[outIdx]), $sformatf("R2 R3 R4 R9 R11 data vec %0d", outIdx),
            outData, expData(VECS[outIdx]));
        chk(outByteEn == expBe(VECS[outIdx]), $sformatf("R5 R6 R7 byte enables vec %0d", outIdx),
            {28'd0, outByteEn}, {28'd0, expBe(VECS[outIdx])});
        outIdx++;
      end
      if (inValid && inReady) inIdx++;
    end
    chk(outIdx == NV, "R9 all words delivered", outIdx, NV);
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);

    // R8 latency into an empty pipeline
    drive(VECS[4]);
    inValid = 1'b1;
    outReady = 1'b1;
    @(negedge clk);  // accepted at the edge just passed
    inValid = 1'b0;
    #1;
    chk(!outValid, "R8 not early", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    #1;
    chk(outValid && outData == expData(VECS[4]), "R8 presented after second edge",
        outData, expData(VECS[4]));

    // R10 and R9: full stall with a third word waiting
    @(negedge clk);
    outReady = 1'b0;
    drive(VECS[0]);
    inValid = 1'b1;
    @(negedge clk);
    drive(VECS[1]);
    @(negedge clk);
    drive(VECS[3]);
    #1;
    chk(!inReady, "R10 ready low when full and stalled", {31'd0, inReady}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk(outValid && outData == expData(VECS[0]), "R9 stalled word held", outData, expData(VECS[0]));
      chk(!inReady, "R10 ready stays low", {31'd0, inReady}, 32'd0);
    end
    inValid = 1'b0;
    outReady = 1'b1;
    #1;
    chk(inReady, "R10 ready returns with consumer", {31'd0, inReady}, 32'd1);
    @(negedge clk);
    #1;
    chk(outValid && outData == expData(VECS[1]), "R9 second word in order", outData, expData(VECS[1]));
    @(negedge clk);
    #1;
    chk(!outValid, "R9 no duplicate after drain", {31'd0, outValid}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule